// File: doc/BRIEF.md
# BCD Calendar Counter with Century Toggle

This block keeps wall-clock time and calendar date in packed BCD. Once per second a single-cycle strobe advances the seconds and lets any rollover ripple through minutes, 24-hour hours, day of week, day of month, month and a two-digit year. An optional century flag flips whenever the year wraps from 99 back to 00. Every field changes on the same clock edge, so a reader sampling the outputs in any cycle always sees one consistent instant.

A host sets the time through a byte-wide load port with a field selector. Loaded values are not range-checked. A digit that is out of range keeps counting from where it was put until its field wraps, and is valid from then on. The block has no bus interface and no prescaler: the strobe comes from a divider outside. Years count as leap years whenever their two-digit value is a multiple of four.

Top module: `rtccal_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the outputs read seconds 0x00, minutes 0x00, hours byte 0x00 (century enable and century flag both 0), day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: On a `tick` cycle with no load, seconds advance in BCD. A field advances only when every lower field wraps on that same tick. Seconds and minutes wrap 0x59 to 0x00, hours wrap 0x23 to 0x00, and all fields take their new values on the same clock edge.
- R3: The date wraps to 0x01 after its last day. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months except February. February ends at 0x29 when the BCD year is a multiple of four and at 0x28 otherwise.
- R4: The month wraps 0x12 to 0x01 and carries into the year. The year wraps 0x99 to 0x00.
- R5: The hours byte holds century enable in bit 7 and the century flag in bit 6. When the year wraps 0x99 to 0x00, the flag inverts if enable is 1 and stays as it was if enable is 0.
- R6: Day of week runs 1 to 7 in bits 2:0 (1 = Sunday) and advances whenever the hours wrap. 7 goes to 1, and a loaded 0 goes to 1.
- R7: An out-of-range digit is not corrected. When the ones digit is 9 or more, an increment clears it and adds one to the tens digit, which wraps within its field width (3 bits for seconds and minutes, 2 for hours and date, 1 for month, 4 for year). A field carries onward only when its whole byte equals its maximum.
- R8: When `wr_en` is high, `wr_data` loads the field chosen by `wr_sel`: 0 seconds [6:0], 1 minutes [6:0], 2 hours byte (bit 7 enable, bit 6 flag, [5:0] hours), 3 day of week [2:0], 4 date [5:0], 5 month [4:0], 6 year [7:0]. Bits outside these ranges always read 0.
- R9: A load cycle suppresses that cycle's tick for every field. `wr_sel` = 7 changes nothing.
- R10: With neither `tick` nor `wr_en`, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 1 Hz advance strobe |
| wr_en | input | 1 | Field load enable |
| wr_sel | input | 3 | Field selector for a load |
| wr_data | input | 8 | Load value |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Century enable, century flag, BCD hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD two-digit year |

## Verification
The assertions assume that `tick` and `wr_en` are settled single-cycle controls and that no condition is set on `wr_data` contents. Invalid digits are legal inputs, so no check assumes that a field is in range, except the rollover checks, which trigger on exact maximum values. The stimulus mixes random loads of valid BCD values, often biased toward field maxima so that carries ripple, with directed loads of invalid digits and a day of week of 0. Years stay valid BCD so that the multiple-of-four leap rule is well defined.

// File: rtl/rtccal_pkg.sv
package rtccal_pkg;

    localparam int BYTE_W    = 8;
    localparam int DIGIT_W   = 4;
    localparam int SEL_W     = 3;
    localparam int DOW_W     = 3;
    localparam int NUM_PAIRS = 6;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } field_e;

    typedef struct packed {
        logic              cen_en;
        logic              cent;
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [DOW_W-1:0]  dow;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] year;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        cen_en: 1'b0, cent: 1'b0,
        sec: 8'h00, min: 8'h00, hour: 8'h00,
        dow: 3'd1, date: 8'h01, month: 8'h01, year: 8'h00
    };

    // Tens digit width of each chained pair: sec, min, hour, date, month, year
    function automatic int tens_width(input int idx);
        case (idx)
            0, 1:    return 3;
            2, 3:    return 2;
            4:       return 1;
            default: return 4;
        endcase
    endfunction

    // Multiple of four in BCD: even tens with ones 0/4/8, odd tens with ones 2/6
    function automatic logic leap_year(input logic [BYTE_W-1:0] yr);
        logic [DIGIT_W-1:0] ones;
        ones = yr[DIGIT_W-1:0];
        if (yr[DIGIT_W] == 1'b0)
            return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
        else
            return (ones == 4'd2) || (ones == 4'd6);
    endfunction

    function automatic logic [BYTE_W-1:0] month_last_day(
        input logic [BYTE_W-1:0] mon,
        input logic [BYTE_W-1:0] yr
    );
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic cal_t apply_load(
        input cal_t              cur,
        input logic [SEL_W-1:0]  sel,
        input logic [BYTE_W-1:0] d
    );
        cal_t r;
        r = cur;
        case (field_e'(sel))
            FLD_SEC:   r.sec   = {1'b0, d[6:0]};
            FLD_MIN:   r.min   = {1'b0, d[6:0]};
            FLD_HOUR: begin
                r.cen_en = d[7];
                r.cent   = d[6];
                r.hour   = {2'b00, d[5:0]};
            end
            FLD_DOW:   r.dow   = d[DOW_W-1:0];
            FLD_DATE:  r.date  = {2'b00, d[5:0]};
            FLD_MONTH: r.month = {3'b000, d[4:0]};
            FLD_YEAR:  r.year  = d;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtccal_bcd_stage.sv
module rtccal_bcd_stage
    import rtccal_pkg::*;
#(
    parameter int TENS_W = 3
) (
    input  logic [BYTE_W-1:0] cur_i,
    input  logic              inc_i,
    input  logic [BYTE_W-1:0] max_i,
    input  logic [BYTE_W-1:0] min_i,
    output logic [BYTE_W-1:0] nxt_o,
    output logic              carry_o
);
    localparam int PAIR_W = DIGIT_W + TENS_W;

    logic [DIGIT_W-1:0] ones;
    logic [TENS_W-1:0]  tens;
    logic [PAIR_W-1:0]  bumped;

    assign ones = cur_i[DIGIT_W-1:0];
    assign tens = cur_i[PAIR_W-1:DIGIT_W];

    always_comb begin
        if (ones >= 4'd9)
            bumped = {tens + TENS_W'(1), {DIGIT_W{1'b0}}};
        else
            bumped = {tens, ones + DIGIT_W'(1)};
    end

    always_comb begin
        nxt_o   = cur_i;
        carry_o = 1'b0;
        if (inc_i) begin
            if (cur_i == max_i) begin
                nxt_o   = min_i;
                carry_o = 1'b1;
            end else begin
                nxt_o = BYTE_W'(bumped);
            end
        end
    end
endmodule

// File: rtl/rtccal_dow_stage.sv
module rtccal_dow_stage
    import rtccal_pkg::*;
(
    input  logic [DOW_W-1:0] cur_i,
    input  logic             inc_i,
    output logic [DOW_W-1:0] nxt_o
);
    localparam logic [DOW_W-1:0] LAST_DAY  = DOW_W'(7);
    localparam logic [DOW_W-1:0] FIRST_DAY = DOW_W'(1);

    always_comb begin
        nxt_o = cur_i;
        if (inc_i)
            nxt_o = (cur_i == LAST_DAY) ? FIRST_DAY : cur_i + DOW_W'(1);
    end
endmodule

// File: rtl/rtccal_advance.sv
module rtccal_advance
    import rtccal_pkg::*;
(
    input  cal_t cur_i,
    input  logic tick_i,
    output cal_t nxt_o
);
    logic [BYTE_W-1:0] cur_f [NUM_PAIRS];
    logic [BYTE_W-1:0] max_f [NUM_PAIRS];
    logic [BYTE_W-1:0] min_f [NUM_PAIRS];
    logic [BYTE_W-1:0] nxt_f [NUM_PAIRS];
    logic              inc_f [NUM_PAIRS];
    logic              cry_f [NUM_PAIRS];
    logic [DOW_W-1:0]  dow_nxt;

    assign cur_f[0] = cur_i.sec;
    assign cur_f[1] = cur_i.min;
    assign cur_f[2] = cur_i.hour;
    assign cur_f[3] = cur_i.date;
    assign cur_f[4] = cur_i.month;
    assign cur_f[5] = cur_i.year;

    assign max_f[0] = 8'h59;
    assign max_f[1] = 8'h59;
    assign max_f[2] = 8'h23;
    assign max_f[3] = month_last_day(cur_i.month, cur_i.year);
    assign max_f[4] = 8'h12;
    assign max_f[5] = 8'h99;

    assign min_f[0] = 8'h00;
    assign min_f[1] = 8'h00;
    assign min_f[2] = 8'h00;
    assign min_f[3] = 8'h01;
    assign min_f[4] = 8'h01;
    assign min_f[5] = 8'h00;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        if (g == 0) begin : g_first
            assign inc_f[g] = tick_i;
        end else begin : g_next
            assign inc_f[g] = cry_f[g-1];
        end
        rtccal_bcd_stage #(.TENS_W(tens_width(g))) u_stage (
            .cur_i   (cur_f[g]),
            .inc_i   (inc_f[g]),
            .max_i   (max_f[g]),
            .min_i   (min_f[g]),
            .nxt_o   (nxt_f[g]),
            .carry_o (cry_f[g])
        );
    end

    rtccal_dow_stage u_dow (
        .cur_i (cur_i.dow),
        .inc_i (cry_f[2]),
        .nxt_o (dow_nxt)
    );

    always_comb begin
        nxt_o        = cur_i;
        nxt_o.sec    = nxt_f[0];
        nxt_o.min    = nxt_f[1];
        nxt_o.hour   = nxt_f[2];
        nxt_o.date   = nxt_f[3];
        nxt_o.month  = nxt_f[4];
        nxt_o.year   = nxt_f[5];
        nxt_o.dow    = dow_nxt;
        nxt_o.cent   = cur_i.cent ^ (cry_f[5] & cur_i.cen_en);
    end
endmodule

// File: rtl/rtccal_core.sv
module rtccal_core
    import rtccal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] sec_o,
    output logic [BYTE_W-1:0] min_o,
    output logic [BYTE_W-1:0] hour_o,
    output logic [BYTE_W-1:0] dow_o,
    output logic [BYTE_W-1:0] date_o,
    output logic [BYTE_W-1:0] month_o,
    output logic [BYTE_W-1:0] year_o
);
    cal_t state_q;
    cal_t adv_d;

    rtccal_advance u_adv (
        .cur_i  (state_q),
        .tick_i (tick),
        .nxt_o  (adv_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= CAL_RESET;
        else if (wr_en)
            state_q <= apply_load(state_q, wr_sel, wr_data);
        else if (tick)
            state_q <= adv_d;
    end

    assign sec_o   = state_q.sec;
    assign min_o   = state_q.min;
    assign hour_o  = {state_q.cen_en, state_q.cent, state_q.hour[5:0]};
    assign dow_o   = {{(BYTE_W-DOW_W){1'b0}}, state_q.dow};
    assign date_o  = state_q.date;
    assign month_o = state_q.month;
    assign year_o  = state_q.year;
endmodule

// File: rtl/rtccal_core_chk.sv
module rtccal_core_chk
    import rtccal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] sec_o,
    input logic [BYTE_W-1:0] min_o,
    input logic [BYTE_W-1:0] hour_o,
    input logic [BYTE_W-1:0] dow_o,
    input logic [BYTE_W-1:0] date_o,
    input logic [BYTE_W-1:0] month_o,
    input logic [BYTE_W-1:0] year_o
);
    logic [7*BYTE_W-1:0] all_o;
    assign all_o = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(all_o));

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_o[7] == 1'b0) && (min_o[7] == 1'b0) && (dow_o[7:3] == 5'd0)
        && (date_o[7:6] == 2'd0) && (month_o[7:5] == 3'd0));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd0) |=> (sec_o == {1'b0, $past(wr_data[6:0])}));

    // R9
    sel7_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd7) |=> $stable(all_o));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && sec_o == 8'h59) |=> (sec_o == 8'h00));

    // R6
    dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && sec_o == 8'h59 && min_o == 8'h59
         && hour_o[5:0] == 6'h23 && dow_o == 8'd7) |=> (dow_o == 8'd1));

    // R5
    century_flip_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && !$past(wr_en) && $past(year_o) == 8'h99 && year_o == 8'h00)
        |-> (hour_o[6] == ($past(hour_o[6]) ^ $past(hour_o[7]))));

    // R4
    month_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && !$past(wr_en) && $past(month_o) == 8'h12 && month_o == 8'h01)
        |-> (year_o != $past(year_o)));
endmodule

bind rtccal_core rtccal_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .sec_o   (sec_o),
    .min_o   (min_o),
    .hour_o  (hour_o),
    .dow_o   (dow_o),
    .date_o  (date_o),
    .month_o (month_o),
    .year_o  (year_o)
);

// File: tb/rtccal_core_bench.sv
module rtccal_core_bench;
    logic       clk = 1'b0;
    logic       rst, tick, wr_en;
    logic [2:0] wr_sel;
    logic [7:0] wr_data;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

    always #2 clk = ~clk;

    rtccal_core u_rtccal_core (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // expected state
    logic [7:0] e_sec, e_min, e_hr, e_date, e_mon, e_yr;
    logic [2:0] e_dow;
    logic       e_cen, e_cent;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic bit is_leap(input logic [7:0] y);
        return ((int'(y[7:4]) * 10 + int'(y[3:0])) % 4) == 0;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
        if (m == 8'h02) return is_leap(y) ? 8'h29 : 8'h28;
        if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11) return 8'h30;
        return 8'h31;
    endfunction

    // R7 rule: equal to max -> min with carry; ones >= 9 -> clear, tens+1 mod 2^tw
    function automatic logic [7:0] pair_step(input logic [7:0] v, input int tw,
                                             input logic [7:0] mx, input logic [7:0] mn,
                                             output bit c);
        int t;
        c = 0;
        if (v == mx) begin c = 1; return mn; end
        if (v[3:0] >= 4'd9) begin
            t = (int'(v[7:4]) + 1) % (1 << tw);
            return 8'(t << 4);
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    task automatic model_reset();
        e_sec = 0; e_min = 0; e_hr = 0; e_date = 8'h01; e_mon = 8'h01; e_yr = 0;
        e_dow = 3'd1; e_cen = 0; e_cent = 0;
    endtask

    task automatic model_tick();
        bit c;
        logic [7:0] ld;
        ld = last_day(e_mon, e_yr);
        e_sec = pair_step(e_sec, 3, 8'h59, 8'h00, c);
        if (!c) return;
        e_min = pair_step(e_min, 3, 8'h59, 8'h00, c);
        if (!c) return;
        e_hr = pair_step(e_hr, 2, 8'h23, 8'h00, c);
        if (!c) return;
        e_dow = (e_dow == 3'd7) ? 3'd1 : e_dow + 3'd1;
        e_date = pair_step(e_date, 2, ld, 8'h01, c);
        if (!c) return;
        e_mon = pair_step(e_mon, 1, 8'h12, 8'h01, c);
        if (!c) return;
        e_yr = pair_step(e_yr, 4, 8'h99, 8'h00, c);
        if (c && e_cen) e_cent = ~e_cent;
    endtask

    task automatic model_load(input logic [2:0] s, input logic [7:0] d);
        case (s)
            3'd0: e_sec = {1'b0, d[6:0]};
            3'd1: e_min = {1'b0, d[6:0]};
            3'd2: begin e_cen = d[7]; e_cent = d[6]; e_hr = {2'b0, d[5:0]}; end
            3'd3: e_dow = d[2:0];
            3'd4: e_date = {2'b0, d[5:0]};
            3'd5: e_mon = {3'b0, d[4:0]};
            3'd6: e_yr = d;
            default: ;
        endcase
    endtask

    task automatic check(input string tag);
        logic [55:0] got, exp;
        got = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
        exp = {e_sec, e_min, e_cen, e_cent, e_hr[5:0], 5'd0, e_dow, e_date, e_mon, e_yr};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input bit t, input bit we, input logic [2:0] s,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        tick = t; wr_en = we; wr_sel = s; wr_data = d;
        @(posedge clk);
        #1;
        if (we) model_load(s, d);
        else if (t) model_tick();
        check(tag);
        @(negedge clk);
        tick = 0; wr_en = 0;
    endtask

    task automatic set_time(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] yr);
        step(0, 1, 3'd0, se, "R8 load sec");
        step(0, 1, 3'd1, mi, "R8 load min");
        step(0, 1, 3'd2, hr, "R8 load hour");
        step(0, 1, 3'd3, dw, "R8 load dow");
        step(0, 1, 3'd4, dt, "R8 load date");
        step(0, 1, 3'd5, mo, "R8 load month");
        step(0, 1, 3'd6, yr, "R8 load year");
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd2024));
        rst = 1; tick = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 check("R1 reset held");
        @(negedge clk) rst = 0;
        @(posedge clk); #1 check("R1 after reset");

        // R2 basic counting
        step(1, 0, 0, 0, "R2 first tick");
        step(0, 0, 0, 0, "R10 idle hold");
        // R5 full rollover with century enabled
        set_time(8'h80 | 8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
        step(1, 0, 0, 0, "R5 R4 R6 full rollover cent toggles");
        // R5 disabled
        set_time(8'h40 | 8'h23, 8'h59, 8'h59, 8'h03, 8'h31, 8'h12, 8'h99);
        step(1, 0, 0, 0, "R5 century disabled keeps flag");
        // R3 leap February
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24);
        step(1, 0, 0, 0, "R3 leap feb 28 to 29");
        step(0, 1, 3'd0, 8'h59, "R8 reload sec");
        step(0, 1, 3'd1, 8'h59, "R8 reload min");
        step(0, 1, 3'd2, 8'h23, "R8 reload hour");
        step(1, 0, 0, 0, "R3 leap feb 29 to mar 01");
        // R3 common February
        set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h28, 8'h02, 8'h23);
        step(1, 0, 0, 0, "R3 common feb 28 to mar 01");
        // R3 thirty-day month
        set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h30, 8'h04, 8'h10);
        step(1, 0, 0, 0, "R3 april 30 to may 01");
        // R6 day of week 0
        set_time(8'h23, 8'h59, 8'h59, 8'h00, 8'h10, 8'h06, 8'h10);
        step(1, 0, 0, 0, "R6 dow zero to one");
        // R7 invalid digits
        step(0, 1, 3'd0, 8'h5C, "R7 load invalid sec");
        step(1, 0, 0, 0, "R7 invalid ones carries to tens");
        step(0, 1, 3'd0, 8'h7A, "R7 load invalid sec tens");
        step(1, 0, 0, 0, "R7 tens wraps without minute carry");
        step(0, 1, 3'd4, 8'hFF, "R8 date masks reserved bits");
        // R9 priority and select 7
        step(1, 1, 3'd1, 8'h42, "R9 load beats tick");
        step(0, 1, 3'd7, 8'hFF, "R9 select 7 no effect");
        step(0, 0, 0, 0, "R10 idle hold");

        // random phase
        set_time(8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom % 100);
            if (r < 15) begin
                logic [2:0] s;
                logic [7:0] d;
                bit near;
                s = 3'($urandom % 8);
                near = ($urandom % 2) == 1;
                case (s)
                    3'd0, 3'd1: d = near ? 8'h59 : to_bcd(int'($urandom % 60));
                    3'd2: d = {2'($urandom), 6'(near ? 8'h23 : to_bcd(int'($urandom % 24)))};
                    3'd3: d = 8'($urandom % 8);
                    3'd4: d = near ? last_day(e_mon, e_yr) : to_bcd(1 + int'($urandom % 31));
                    3'd5: d = near ? 8'h12 : to_bcd(1 + int'($urandom % 12));
                    3'd6: d = near ? 8'h99 : to_bcd(int'($urandom % 100));
                    default: d = 8'($urandom);
                endcase
                step(($urandom % 2) == 1, 1, s, d, "R8 R9 random load");
            end else if (r < 90) begin
                step(1, 0, 0, 0, "R2 random tick");
            end else begin
                step(0, 0, 0, 0, "R10 random idle");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule